// File: doc/BRIEF.md
# Double-Buffered Dual-Channel Converter Code Loader

This block is a clocked register front end that feeds two 12-bit converter channels from an 8-bit processor bus. The bus side has an active-low chip select, an active-low write strobe, a 2-bit section address and an 8-bit data bus. A separate active-low load strobe is not tied to the write cycle. All of these pins arrive asynchronously. The block runs them through a synchroniser into the system clock domain and detects their edges there.

Each channel has two stages. The hidden input stage has a 4-bit high section and an 8-bit low section, and each section is filled by its own byte write. The sections can be written in any order. The output stage drives the 12-bit code sent to the external converter. A rising edge on the load strobe copies both input stages into both output stages in the same clock cycle. Each output carries a one-cycle valid pulse on the cycle its code is refreshed.

The converters always accept a new code, so the outputs have no ready signal and no back-pressure. A code is held until the next transfer. Software writes up to four byte sections and then pulses the load strobe. This changes both channels together.

Top module: `dual_dac_loader`

## Requirements
- R1: Reset clears both input stages and both output codes to zero, and both valid flags are low.
- R2: A write with address 00 stores data bits 7..0 into channel A code bits 7..0. While load stays high, no write changes either output code.
- R3: A write with address 01 stores data bits 3..0 into channel A code bits 11..8. Data bits 7..4 are ignored.
- R4: Addresses 10 and 11 load the low and high sections of channel B in the same way as R2 and R3. Address bit 1 selects the channel and address bit 0 selects high (1) or low (0).
- R5: A write strobe pulse while chip select is high changes no input section.
- R6: The high and low sections can be written in either order, and the result is the same.
- R7: A rising edge of the load strobe copies both input stages into both output codes in the same cycle. Both valid flags pulse together in that cycle.
- R8: An output code changes only in a cycle where its valid flag is high. A falling edge of load, or holding load low, moves nothing.
- R9: If a write rising edge and a load rising edge are detected in the same cycle, the write completes first. The transfer follows one cycle later and carries the new data.
- R10: Each valid flag is high for exactly one cycle per transfer.
- R11: A transfer does not clear the input stages. A second load with no writes in between reissues the same codes and pulses the valid flags again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| bus_addr | input | 2 | Section select: bit 1 is the channel, bit 0 selects high |
| bus_data | input | 8 | Right-justified data byte |
| load_n | input | 1 | Transfer strobe, active low; acts on its rising edge |
| code_a_o | output | 12 | Channel A converter code |
| code_b_o | output | 12 | Channel B converter code |
| code_a_valid | output | 1 | One-cycle pulse when code_a_o is refreshed |
| code_b_valid | output | 1 | One-cycle pulse when code_b_o is refreshed |

## Verification
The checks assume that chip select, address and data are stable from the falling edge of write until several clocks after its rising edge. They also assume each strobe stays at each level for at least two clocks, so the synchroniser sees every edge. The bench drives every pin on the falling clock edge. Each strobe level is held for three or more cycles, and bus values are held past write release, both in the random byte writes and in the directed cases where write and load rise together. Under these conditions the checks compare the outputs against a model of the input and output stages kept by the bench. They confirm that codes move only with their valid flags, that the two flags stay identical, and that each flag pulse lasts one cycle.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int CODE_W = 12;
  localparam int BUS_W  = 8;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = $clog2(NUM_CH) + 1;
  localparam int HI_W   = CODE_W - BUS_W;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {SEC_LOW = 1'b0, SEC_HIGH = 1'b1} section_e;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= RST_VAL;
    else        prev_o <= chain[STAGES-1];
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/dacif_input_bank.sv
module dacif_input_bank
  import dacif_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BUS_W,
  parameter int NC = NUM_CH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NC):0]         wr_addr,
  input  logic [BW-1:0]               wr_data,
  output logic [NC-1:0][CW-1:0]       staged_o
);
  localparam int HW = CW - BW;
  localparam int AW = $clog2(NC) + 1;

  logic [AW-2:0] ch_sel;
  section_e      sec_sel;

  assign ch_sel  = wr_addr[AW-1:1];
  assign sec_sel = section_e'(wr_addr[0]);

  generate
    for (genvar c = 0; c < NC; c++) begin : g_ch
      logic [BW-1:0] low_q;
      logic [HW-1:0] high_q;
      logic          hit;

      assign hit = wr_en && (ch_sel == c[AW-2:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          low_q  <= '0;
          high_q <= '0;
        end else if (hit) begin
          if (sec_sel == SEC_HIGH) high_q <= wr_data[HW-1:0];
          else                     low_q  <= wr_data;
        end
      end

      assign staged_o[c] = {high_q, low_q};
    end
  endgenerate
endmodule

// File: rtl/dacif_xfer.sv
module dacif_xfer
  import dacif_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NC = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_rise,
  input  logic                  wr_commit,
  input  logic [NC-1:0][CW-1:0] staged_i,
  output logic [NC-1:0][CW-1:0] code_o,
  output logic [NC-1:0]         valid_o
);
  logic deferred_q;
  logic move_now;

  // A load edge coinciding with a byte commit waits one cycle so it sees the new byte.
  assign move_now = deferred_q || (load_rise && !wr_commit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) deferred_q <= 1'b0;
    else        deferred_q <= load_rise && wr_commit;
  end

  generate
    for (genvar c = 0; c < NC; c++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_o[c]  <= '0;
          valid_o[c] <= 1'b0;
        end else begin
          valid_o[c] <= move_now;
          if (move_now) code_o[c] <= staged_i[c];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacif_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BUS_W,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_data,
  input  logic          load_n,
  output logic [CW-1:0] code_a_o,
  output logic [CW-1:0] code_b_o,
  output logic          code_a_valid,
  output logic          code_b_valid
);
  localparam int NC = 2;
  localparam int AW = 2;
  localparam int PW = 3 + AW + BW;
  localparam logic [PW-1:0] IDLE = {3'b111, {(AW + BW){1'b0}}};

  logic [PW-1:0] pins, cur, prev;
  assign pins = {bus_cs_n, bus_wr_n, load_n, bus_addr, bus_data};

  dacif_sync #(.W(PW), .STAGES(SYNC_N), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins), .sync_o(cur), .prev_o(prev)
  );

  logic          prev_cs_n, prev_wr_n, prev_ld_n, cur_wr_n, cur_ld_n;
  logic [AW-1:0] prev_addr;
  logic [BW-1:0] prev_data;

  assign {prev_cs_n, prev_wr_n, prev_ld_n, prev_addr, prev_data} = prev;
  assign cur_wr_n = cur[PW-2];
  assign cur_ld_n = cur[PW-3];

  logic wr_commit, load_rise;
  // Bus fields are taken from the sample held while write was still low.
  assign wr_commit = !prev_wr_n && cur_wr_n && !prev_cs_n;
  assign load_rise = !prev_ld_n && cur_ld_n;

  logic [NC-1:0][CW-1:0] staged, codes;
  logic [NC-1:0]         valids;

  dacif_input_bank #(.CW(CW), .BW(BW), .NC(NC)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_addr(prev_addr),
    .wr_data(prev_data), .staged_o(staged)
  );

  dacif_xfer #(.CW(CW), .NC(NC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .load_rise(load_rise), .wr_commit(wr_commit),
    .staged_i(staged), .code_o(codes), .valid_o(valids)
  );

  assign code_a_o     = codes[0];
  assign code_b_o     = codes[1];
  assign code_a_valid = valids[0];
  assign code_b_valid = valids[1];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] code_a_o,
  input logic [CW-1:0] code_b_o,
  input logic          code_a_valid,
  input logic          code_b_valid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (code_a_o == '0 && code_b_o == '0 && !code_a_valid && !code_b_valid))
    else $error("reset did not clear outputs");

  p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_a_valid |-> $stable(code_a_o))
    else $error("code A moved without valid");

  p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_b_valid |-> $stable(code_b_o))
    else $error("code B moved without valid");

  p_flags_paired_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_a_valid == code_b_valid)
    else $error("valid flags differ");

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    code_a_valid |=> !code_a_valid)
    else $error("valid held longer than one cycle");
endmodule

bind dual_dac_loader dacif_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_a_o(code_a_o), .code_b_o(code_b_o),
  .code_a_valid(code_a_valid), .code_b_valid(code_b_valid)
);

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic [11:0] code_a, code_b;
  logic va, vb;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  logic [11:0] m_out [2];

  always #2 clk = ~clk;

  dual_dac_loader dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_addr(addr),
    .bus_data(data), .load_n(ld_n), .code_a_o(code_a), .code_b_o(code_b),
    .code_a_valid(va), .code_b_valid(vb)
  );

  always @(negedge clk) if (rst_n && va) pulses++;

  function automatic logic [11:0] staged(input int c);
    return {m_hi[c], m_lo[c]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk); cs_n = sel_n; addr = a; data = d; wr_n = 1'b0;
    cyc(3); wr_n = 1'b1;
    cyc(3); cs_n = 1'b1;
    cyc(2);
    if (!sel_n) begin
      if (a[0]) m_hi[a[1]] = d[3:0];
      else      m_lo[a[1]] = d;
    end
  endtask

  task automatic load_pulse();
    @(negedge clk); ld_n = 1'b0;
    cyc(3); ld_n = 1'b1;
    cyc(6);
    m_out[0] = staged(0); m_out[1] = staged(1);
  endtask

  task automatic check_outs(input string tag);
    check(tag, code_a, m_out[0]);
    check(tag, code_b, m_out[1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int p0;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_out[c] = '0; end
    cyc(3);
    // R1: reset state
    check("R1 code_a", code_a, 12'h000);
    check("R1 code_b", code_b, 12'h000);
    check("R1 valid", {va, vb}, 2'b00);
    rst_n = 1'b1; cyc(3);

    // R2/R3: channel A, upper data nibble ignored on high write
    bus_write(2'b00, 8'hA5, 1'b0);
    bus_write(2'b01, 8'hF3, 1'b0);
    check_outs("R2 no change before load");
    p0 = pulses;
    load_pulse();
    check("R3 code_a", code_a, 12'h3A5);
    check("R7 one pulse per load", pulses - p0, 1);

    // R4/R6: channel B, high section written first
    bus_write(2'b11, 8'h0C, 1'b0);
    bus_write(2'b10, 8'h7E, 1'b0);
    load_pulse();
    check("R4 code_b", code_b, 12'hC7E);
    check("R6 code_a kept", code_a, 12'h3A5);

    // R5: chip select high blocks the write
    bus_write(2'b00, 8'h11, 1'b1);
    load_pulse();
    check("R5 code_a", code_a, 12'h3A5);

    // R8: load held low moves nothing
    bus_write(2'b01, 8'h09, 1'b0);
    @(negedge clk); ld_n = 1'b0; cyc(10);
    check("R8 held low a", code_a, 12'h3A5);
    ld_n = 1'b1; cyc(6);
    m_out[0] = staged(0); m_out[1] = staged(1);
    check("R8 after rise a", code_a, 12'h9A5);

    // R11: repeat load without writes
    p0 = pulses;
    load_pulse();
    check_outs("R11 same codes");
    check("R11 pulse", pulses - p0, 1);

    // R9: write and load rise together
    for (int k = 0; k < 2; k++) begin
      logic [1:0] a2 = (k == 0) ? 2'b10 : 2'b01;
      logic [7:0] d2 = (k == 0) ? 8'h5A : 8'h06;
      @(negedge clk); cs_n = 1'b0; addr = a2; data = d2; wr_n = 1'b0; ld_n = 1'b0;
      cyc(3); wr_n = 1'b1; ld_n = 1'b1;
      cyc(4); cs_n = 1'b1; cyc(2);
      if (a2[0]) m_hi[a2[1]] = d2[3:0]; else m_lo[a2[1]] = d2;
      m_out[0] = staged(0); m_out[1] = staged(1);
      check_outs("R9 coincident");
    end

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int nw = $urandom_range(1, 4);
      for (int w = 0; w < nw; w++)
        bus_write(2'($urandom_range(0, 3)), 8'($urandom), logic'($urandom_range(0, 4) == 0));
      check_outs("R2 random pre-load");
      p0 = pulses;
      load_pulse();
      check_outs("R7 random");
      check("R10 random pulse", pulses - p0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule